// File: doc/BRIEF.md
# Stuck-State Hang Signature Detector

This block decides whether a baseband or a MAC datapath has locked up. On a request it watches a 32-bit baseband observation word and, if needed, four 32-bit DMA debug words. A word only counts as "stuck" when a reference sample is followed by a run of further samples that all equal it. Once a value is stuck, it is compared against a short table of signatures, and the first matching signature gives a hang code.

The baseband check runs first. The MAC check runs only if the baseband check reports no hang. A baseband check that is aborted by a changing word also reports no hang, so the MAC check still follows when it is enabled. The request carries one enable bit per check. The block raises `done_o` for one cycle when it finishes and holds the code until the next completion.

States: `ST_IDLE` (waits for a request), `ST_BB_COUNT` (stability run on the observation word), `ST_BB_MATCH` (table lookup), `ST_MAC_COUNT` (stability run on the four debug words), `ST_MAC_MATCH` (signature lookup) and `ST_DONE` (one-cycle completion). Transitions:
- `ST_IDLE` goes to `ST_BB_COUNT` on a request with the baseband enable set. With only the MAC enable set it goes to `ST_MAC_COUNT`. With neither set it goes to `ST_DONE` with no hang.
- `ST_BB_COUNT` goes to `ST_BB_MATCH` when the word is stable. If the word changes it goes to `ST_MAC_COUNT` when the MAC check is enabled, and to `ST_DONE` otherwise.
- `ST_BB_MATCH` goes to `ST_DONE` on a hit. On a miss it goes to `ST_MAC_COUNT` when the MAC check is enabled, and to `ST_DONE` otherwise.
- `ST_MAC_COUNT` goes to `ST_MAC_MATCH` when the words are stable, and to `ST_DONE` if they change.
- `ST_MAC_MATCH` goes to `ST_DONE`.
- `ST_DONE` goes to `ST_IDLE`.

Top module: `hang_sig_detector`

## Requirements
- R1: After reset, `done_o` is 0 and `code_o` is 0.
- R2: A check reaches its signature lookup only after one reference sample plus `STABLE_N` (default 50) further samples on `smp_vld_i`, all equal to the reference. Cycles without `smp_vld_i` do not count.
- R3: If any sample during a run differs from the reference, that check ends with no hang. After an aborted baseband check, the MAC check still runs when it is enabled.
- R4: Code values are: 0 none, 1 baseband DFS-type, 2 baseband RIFS-type, 3 baseband RX-clear-type, 4 MAC signature 1, 5 MAC signature 2.
- R5: Under mask 0x7E000B00, the baseband word gives code 1 if the masked word equals 0x1E000000, code 2 if it equals 0x52000B00, and code 3 if it equals 0x18000B00. Otherwise, under mask 0x7E7FFFEF, a masked word equal to 0x00702400 gives code 3. Bits outside the masks have no effect. The earlier entry wins.
- R6: When the baseband check finds a hang, the MAC check is skipped and the baseband code is reported.
- R7: MAC signature 1 holds when debug word 6 bits [1:0] equal 1 and at least one 5-bit field equals 6. The fields scanned are the six fields at bit offsets 0,5,...,25 of debug word 4 and the four fields at offsets 0,5,10,15 of debug word 5. Other bits are not scanned.
- R8: MAC signature 2 holds when debug word 3 has bits [21:18]=9, bits [25:22]=8 and bits [28:26]=4.
- R9: Signature 1 is checked before signature 2. Stuck MAC words that match neither give code 0.
- R10: A request with both enables low completes with code 0 without waiting for any sample.
- R11: `done_o` is a one-cycle pulse. `code_o` keeps its value until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start a detection (taken only when idle) |
| req_bb_i | input | 1 | Enable the baseband check for this request |
| req_mac_i | input | 1 | Enable the MAC check for this request |
| smp_vld_i | input | 1 | Sample strobe for the watched words |
| obs_i | input | 32 | Baseband observation word |
| dbg3_i | input | 32 | DMA debug word 3 |
| dbg4_i | input | 32 | DMA debug word 4 |
| dbg5_i | input | 32 | DMA debug word 5 |
| dbg6_i | input | 32 | DMA debug word 6 |
| done_o | output | 1 | One-cycle completion pulse |
| code_o | output | 3 | Hang code of the last completed detection |

## Verification
The assertions check, on every cycle, that:
- a completion pulse lasts one cycle;
- the code stays within its six values;
- the run counter never passes its limit and an abort stays latched until the next request;
- a lookup state is entered only from a finished stability run;
- a baseband hit always leads straight to completion.

Only the bench scenarios can show the table values themselves: the masks, the entry priority, the field positions of the MAC scan and the exact number of samples needed. They can also show that an aborted baseband run hands over to the MAC check.

// File: rtl/hang_det_pkg.sv
package hang_det_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_BB_COUNT  = 3'd1,
        ST_BB_MATCH  = 3'd2,
        ST_MAC_COUNT = 3'd3,
        ST_MAC_MATCH = 3'd4,
        ST_DONE      = 3'd5
    } det_state_e;

    typedef enum logic [1:0] {
        TK_EMPTY    = 2'd0,
        TK_COUNTING = 2'd1,
        TK_STABLE   = 2'd2,
        TK_BROKEN   = 2'd3
    } track_state_e;

    localparam logic [2:0] HC_NONE     = 3'd0;
    localparam logic [2:0] HC_BB_DFS   = 3'd1;
    localparam logic [2:0] HC_BB_RIFS  = 3'd2;
    localparam logic [2:0] HC_BB_RXCLR = 3'd3;
    localparam logic [2:0] HC_MAC_SIG1 = 3'd4;
    localparam logic [2:0] HC_MAC_SIG2 = 3'd5;

    localparam int BB_ENTRIES = 4;

    function automatic logic [31:0] bb_mask(input int idx);
        return (idx == 3) ? 32'h7E7F_FFEF : 32'h7E00_0B00;
    endfunction

    function automatic logic [31:0] bb_value(input int idx);
        logic [31:0] v;
        unique case (idx)
            0:       v = 32'h1E00_0000;
            1:       v = 32'h5200_0B00;
            2:       v = 32'h1800_0B00;
            default: v = 32'h0070_2400;
        endcase
        return v;
    endfunction

    function automatic logic [2:0] bb_code(input int idx);
        logic [2:0] c;
        unique case (idx)
            0:       c = HC_BB_DFS;
            1:       c = HC_BB_RIFS;
            default: c = HC_BB_RXCLR;
        endcase
        return c;
    endfunction

    localparam logic [4:0] SIG1_FIELD     = 5'h06;
    localparam logic [1:0] SIG1_COMPLETE  = 2'h1;
    localparam logic [3:0] SIG2_STITCH    = 4'h9;
    localparam logic [3:0] SIG2_FETCH     = 4'h8;
    localparam logic [2:0] SIG2_COMPLETE  = 3'h4;

endpackage

// File: rtl/hang_stab_track.sv
module hang_stab_track
    import hang_det_pkg::*;
#(
    parameter int W        = 32,
    parameter int STABLE_N = 50
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         en_i,
    input  logic         smp_vld_i,
    input  logic [W-1:0] word_i,
    output logic         stable_o,
    output logic         broken_o,
    output logic [W-1:0] ref_o
);
    localparam int CW = $clog2(STABLE_N + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(STABLE_N);

    track_state_e tk_q;
    logic [CW-1:0] cnt_q;
    logic [W-1:0]  ref_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tk_q  <= TK_EMPTY;
            cnt_q <= '0;
            ref_q <= '0;
        end else if (clear_i) begin
            tk_q  <= TK_EMPTY;
            cnt_q <= '0;
        end else if (en_i && smp_vld_i) begin
            unique case (tk_q)
                TK_EMPTY: begin
                    ref_q <= word_i;
                    cnt_q <= '0;
                    tk_q  <= TK_COUNTING;
                end
                TK_COUNTING: begin
                    if (word_i != ref_q) begin
                        tk_q <= TK_BROKEN;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q + 1'b1 == CNT_LAST) tk_q <= TK_STABLE;
                    end
                end
                default: ;
            endcase
        end
    end

    assign stable_o = (tk_q == TK_STABLE);
    assign broken_o = (tk_q == TK_BROKEN);
    assign ref_o    = ref_q;

    // R2: the run counter never exceeds the stability length
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LAST);

    // R3: an abort stays latched until the next request clears it
    a_r3_broken_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (broken_o && !clear_i) |=> broken_o);

endmodule

// File: rtl/hang_bb_match.sv
module hang_bb_match
    import hang_det_pkg::*;
(
    input  logic [31:0] word_i,
    output logic [2:0]  code_o
);
    logic [BB_ENTRIES-1:0] hit;

    for (genvar g = 0; g < BB_ENTRIES; g++) begin : g_entry
        assign hit[g] = ((word_i & bb_mask(g)) == bb_value(g));
    end

    always_comb begin
        code_o = HC_NONE;
        for (int i = BB_ENTRIES - 1; i >= 0; i--) begin
            if (hit[i]) code_o = bb_code(i);
        end
    end

endmodule

// File: rtl/hang_mac_match.sv
module hang_mac_match
    import hang_det_pkg::*;
#(
    parameter int FW  = 5,
    parameter int N4  = 6,
    parameter int N5  = 4
) (
    input  logic [31:0] d3_i,
    input  logic [31:0] d4_i,
    input  logic [31:0] d5_i,
    input  logic [31:0] d6_i,
    output logic [2:0]  code_o
);
    localparam int NF = N4 + N5;

    logic [NF-1:0] fhit;
    logic          sig1, sig2;

    for (genvar g = 0; g < N4; g++) begin : g_d4
        assign fhit[g] = (d4_i[g*FW +: FW] == SIG1_FIELD);
    end
    for (genvar g = 0; g < N5; g++) begin : g_d5
        assign fhit[N4+g] = (d5_i[g*FW +: FW] == SIG1_FIELD);
    end

    assign sig1 = (|fhit) && (d6_i[1:0] == SIG1_COMPLETE);
    assign sig2 = (d3_i[21:18] == SIG2_STITCH) &&
                  (d3_i[25:22] == SIG2_FETCH)  &&
                  (d3_i[28:26] == SIG2_COMPLETE);

    always_comb begin
        if (sig1)      code_o = HC_MAC_SIG1;
        else if (sig2) code_o = HC_MAC_SIG2;
        else           code_o = HC_NONE;
    end

endmodule

// File: rtl/hang_sig_detector.sv
module hang_sig_detector
    import hang_det_pkg::*;
#(
    parameter int STABLE_N = 50
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_i,
    input  logic        req_bb_i,
    input  logic        req_mac_i,
    input  logic        smp_vld_i,
    input  logic [31:0] obs_i,
    input  logic [31:0] dbg3_i,
    input  logic [31:0] dbg4_i,
    input  logic [31:0] dbg5_i,
    input  logic [31:0] dbg6_i,
    output logic        done_o,
    output logic [2:0]  code_o
);
    localparam int MW = 4 * 32;

    det_state_e state_q, state_d;
    logic       mac_en_q;
    logic [2:0] result_q, result_d;
    logic       load_d;
    logic       start;

    logic          bb_stable, bb_broken, mac_stable, mac_broken;
    logic [31:0]   bb_ref;
    logic [MW-1:0] mac_ref;
    logic [2:0]    bb_code_w, mac_code_w;

    assign start = (state_q == ST_IDLE) && req_i;

    hang_stab_track #(.W(32), .STABLE_N(STABLE_N)) u_bb_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (start),
        .en_i     (state_q == ST_BB_COUNT),
        .smp_vld_i(smp_vld_i),
        .word_i   (obs_i),
        .stable_o (bb_stable),
        .broken_o (bb_broken),
        .ref_o    (bb_ref)
    );

    hang_stab_track #(.W(MW), .STABLE_N(STABLE_N)) u_mac_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (start),
        .en_i     (state_q == ST_MAC_COUNT),
        .smp_vld_i(smp_vld_i),
        .word_i   ({dbg6_i, dbg5_i, dbg4_i, dbg3_i}),
        .stable_o (mac_stable),
        .broken_o (mac_broken),
        .ref_o    (mac_ref)
    );

    hang_bb_match u_bb_match (
        .word_i(bb_ref),
        .code_o(bb_code_w)
    );

    hang_mac_match u_mac_match (
        .d3_i  (mac_ref[31:0]),
        .d4_i  (mac_ref[63:32]),
        .d5_i  (mac_ref[95:64]),
        .d6_i  (mac_ref[127:96]),
        .code_o(mac_code_w)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            mac_en_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start) mac_en_q <= req_mac_i;
        end
    end

    // next state and result selection
    always_comb begin
        state_d  = state_q;
        result_d = HC_NONE;
        load_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_i) begin
                    if (req_bb_i)       state_d = ST_BB_COUNT;
                    else if (req_mac_i) state_d = ST_MAC_COUNT;
                    else begin
                        state_d = ST_DONE;
                        load_d  = 1'b1;
                    end
                end
            end
            ST_BB_COUNT: begin
                if (bb_broken) begin
                    if (mac_en_q) state_d = ST_MAC_COUNT;
                    else begin
                        state_d = ST_DONE;
                        load_d  = 1'b1;
                    end
                end else if (bb_stable) begin
                    state_d = ST_BB_MATCH;
                end
            end
            ST_BB_MATCH: begin
                if (bb_code_w != HC_NONE) begin
                    state_d  = ST_DONE;
                    result_d = bb_code_w;
                    load_d   = 1'b1;
                end else if (mac_en_q) begin
                    state_d = ST_MAC_COUNT;
                end else begin
                    state_d = ST_DONE;
                    load_d  = 1'b1;
                end
            end
            ST_MAC_COUNT: begin
                if (mac_broken) begin
                    state_d = ST_DONE;
                    load_d  = 1'b1;
                end else if (mac_stable) begin
                    state_d = ST_MAC_MATCH;
                end
            end
            ST_MAC_MATCH: begin
                state_d  = ST_DONE;
                result_d = mac_code_w;
                load_d   = 1'b1;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      result_q <= HC_NONE;
        else if (load_d) result_q <= result_d;
    end

    always_comb begin
        done_o = (state_q == ST_DONE);
        code_o = result_q;
    end

    // R11: completion is a single-cycle pulse
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R4: the reported code stays within the defined set
    a_r4_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        code_o <= HC_MAC_SIG2);

    // R6: a baseband hit never leads into the MAC run
    a_r6_bb_hit_skips_mac: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BB_MATCH && bb_code_w != HC_NONE) |=> (state_q == ST_DONE));

    // R2: the baseband lookup is entered only after a finished run
    a_r2_bb_match_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BB_COUNT && !bb_stable) |=> (state_q != ST_BB_MATCH));

    // R2: the MAC lookup is entered only after a finished run
    a_r2_mac_match_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MAC_COUNT && !mac_stable) |=> (state_q != ST_MAC_MATCH));

    // R10: a request without any enable completes on the next cycle
    a_r10_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !req_bb_i && !req_mac_i) |=> done_o);

endmodule

// File: tb/hang_sig_detector_tb.sv
module hang_sig_detector_tb;
    localparam int NV = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_bb = 1'b0, req_mac = 1'b0, smp_vld = 1'b0;
    logic [31:0] obs = '0, d3 = '0, d4 = '0, d5 = '0, d6 = '0;
    logic        done;
    logic [2:0]  code;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    hang_sig_detector u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .req_bb_i(req_bb),
        .req_mac_i(req_mac), .smp_vld_i(smp_vld), .obs_i(obs),
        .dbg3_i(d3), .dbg4_i(d4), .dbg5_i(d5), .dbg6_i(d6),
        .done_o(done), .code_o(code)
    );

    // vectors: obs, d3, d4, d5, d6, {bb_en, mac_en}, expected code
    localparam logic [31:0] V_OBS [NV] = '{
        32'h1E00_0000, 32'h5200_0B00, 32'h1800_0B00, 32'h0070_2410,
        32'h9E00_0000, 32'h1234_5678, 32'h1234_5678, 32'h1234_5678,
        32'h1234_5678, 32'h1234_5678, 32'h1234_5678, 32'h1234_5678,
        32'h1E00_0000, 32'h1E00_0000};
    localparam logic [31:0] V_D3 [NV] = '{
        0, 0, 0, 0, 0, 0, 0, 0, 32'h1224_0000, 32'h1224_0000, 0, 0, 0, 0};
    localparam logic [31:0] V_D4 [NV] = '{
        0, 0, 0, 0, 0, 0, 32'h0000_1800, 0, 0, 32'h0C00_0000, 32'h0000_1800, 0,
        32'h0000_0006, 0};
    localparam logic [31:0] V_D5 [NV] = '{
        0, 0, 0, 0, 0, 0, 0, 32'h0003_0000, 0, 0, 0, 32'h0060_0000, 0, 0};
    localparam logic [31:0] V_D6 [NV] = '{
        0, 0, 0, 0, 0, 0, 32'h1, 32'h5, 0, 32'h1, 32'h2, 32'h1, 32'h1, 0};
    localparam logic [1:0] V_EN [NV] = '{
        2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b11, 2'b01,
        2'b01, 2'b11, 2'b01, 2'b01, 2'b11, 2'b00};
    localparam logic [2:0] V_EXP [NV] = '{
        3'd1, 3'd2, 3'd3, 3'd3, 3'd1, 3'd0, 3'd4, 3'd4,
        3'd5, 3'd4, 3'd0, 3'd0, 3'd1, 3'd0};
    localparam string V_REQ [NV] = '{
        "R5", "R5", "R5", "R5", "R5", "R5", "R7", "R7",
        "R8", "R9", "R7", "R7", "R6", "R10"};

    task automatic check(input string rq, input string what,
                         input int act, input int exp_v);
        n_cmp++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp_v);
        end
    endtask

    // run one detection; chg_at>0 flips obs bit 0 at that sample index
    task automatic run_det(input logic [31:0] o, input logic [31:0] w3,
                           input logic [31:0] w4, input logic [31:0] w5,
                           input logic [31:0] w6, input logic [1:0] en,
                           input int chg_at, output int got, output int seen);
        @(negedge clk);
        obs = o; d3 = w3; d4 = w4; d5 = w5; d6 = w6;
        req_bb = en[1]; req_mac = en[0]; req = 1'b1; smp_vld = 1'b0;
        @(negedge clk);
        req = 1'b0; smp_vld = 1'b1;
        seen = 0; got = -1;
        for (int i = 0; i < 400; i++) begin
            if (done) begin
                got = int'(code);
                seen = 1;
                break;
            end
            obs = (chg_at > 0 && i == chg_at) ? (o ^ 32'h1) : o;
            @(negedge clk);
        end
        smp_vld = 1'b0;
        obs = o;
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int got, seen, cnt;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "done after reset", int'(done), 0);
        check("R1", "code after reset", int'(code), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R4..R10
        for (int v = 0; v < NV; v++) begin
            run_det(V_OBS[v], V_D3[v], V_D4[v], V_D5[v], V_D6[v], V_EN[v], 0, got, seen);
            check(V_REQ[v], $sformatf("vector %0d done seen", v), seen, 1);
            check(V_REQ[v], $sformatf("vector %0d code (R4)", v), got, int'(V_EXP[v]));
        end

        // R11: code held, done low afterwards
        run_det(32'h5200_0B00, 0, 0, 0, 0, 2'b10, 0, got, seen);
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (done) cnt++;
            if (code != 3'd2) cnt += 100;
        end
        check("R11", "extra pulses / code change", cnt, 0);

        // R3: baseband change aborts, bb only
        run_det(32'h1E00_0000, 0, 0, 0, 0, 2'b10, 10, got, seen);
        check("R3", "bb abort code", got, 0);
        // R3: baseband abort hands over to MAC check
        run_det(32'h1E00_0000, 32'h1224_0000, 0, 0, 0, 2'b11, 10, got, seen);
        check("R3", "bb abort then mac sig2", got, 5);
        // R3: change on last required sample still aborts
        run_det(32'h1E00_0000, 0, 0, 0, 0, 2'b10, 50, got, seen);
        check("R3", "abort on final sample", got, 0);

        // R2: reference + 49 further samples is not enough
        @(negedge clk);
        obs = 32'h1E00_0000; req_bb = 1'b1; req_mac = 1'b0; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        seen = 0;
        for (int i = 0; i < 50; i++) begin
            smp_vld = 1'b1;
            @(negedge clk);
            if (done) seen = 1;
        end
        smp_vld = 1'b0;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
        check("R2", "done before last sample", seen, 0);
        smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
        for (int i = 0; i < 6; i++) begin
            if (done) seen = 1;
            @(negedge clk);
        end
        check("R2", "done after last sample", seen, 1);
        check("R2", "code after full run", int'(code), 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule